// File: doc/BRIEF.md
# Translation Cache Range Purge Unit

This block is a small, fully associative translation cache. It keeps separate instruction-side and data-side arrays. Each entry holds a region identifier, a page base address and a page size given as a log2 value. A fill port writes an entry into a chosen slot. A combinational lookup port reports whether an address hits on a chosen side. Eight region registers map the top three bits of any 64-bit address to a region identifier. Fills, lookups and purges all resolve the identifier through these registers.

The purge command port accepts a 64-bit address operand, a 64-bit size operand and a qualifying predicate. With the predicate set, the block runs four checks in priority order: privilege, operand not-a-thing flags, unimplemented address bits and virtualization mode. It reports the first check that fails as a fault code and changes nothing. When every check passes, the block asks for pending stores to drain and waits for the acknowledge. It then invalidates, in one sweep cycle, every entry in the selected region whose page overlaps the aligned purge range. The sweep covers both arrays. The block pulses `done` when each command finishes.

Top module: `tc_range_purge`

## Requirements
- R1: A fill writes slot `fillIdx` of array `fillSide` (0 = instruction, 1 = data). The slot takes the region identifier of register `fillAddr[63:61]`, the base `fillAddr[60:0]` aligned down to 2^`fillPs`, and the size `fillPs`. `lookHit` is 1 when a valid entry on `lookSide` has the region identifier of register `lookAddr[63:61]` and its page contains `lookAddr[60:0]`.
- R2: A purge that passes its checks invalidates every entry, in both arrays, whose region identifier equals that of register `cmdAddr[63:61]` and whose page overlaps the purge range. This holds when the entry page contains the range and also when the range contains the entry page.
- R3: A purge leaves valid any entry whose region identifier differs, or whose page does not overlap the range.
- R4: The purge range is 2^`cmdSize[7:2]` bytes. It starts at `cmdAddr[60:0]` aligned down to that size, so an unaligned purge address removes a page that holds the aligned base.
- R5: When the predicate is set and `curPl` is nonzero, the block reports fault code 1 (privilege), does not request a store drain and leaves every entry unchanged.
- R6: When the predicate is set, `curPl` is 0 and `cmdAddrNat` or `cmdSizeNat` is 1, the block reports fault code 2 (not-a-thing).
- R7: When the earlier checks pass and any bit of `cmdAddr[60:VA_IMPL]` is 1, the block reports fault code 3 (unimplemented address).
- R8: When the earlier checks pass and `virtMode` is 1, the block reports fault code 4 (virtualization).
- R9: The checks are ranked privilege, then not-a-thing, then unimplemented address, then virtualization. Only the first failing check is reported. Every fault comes with `fault` = 1 and `done` = 1 in the cycle after the command, and no entry changes.
- R10: A command with `cmdQp` = 0 pulses `done` one cycle later with `fault` = 0. It changes no entry, even when its operands would fault.
- R11: On a passing purge, `drainReq` rises one cycle after the command and stays high until `drainAck`. Entries stay present until one sweep cycle after the acknowledge. `done` pulses in the cycle after the sweep.
- R12: While `busy` is 1, the block ignores fills and ignores new commands.
- R13: After reset, every entry is invalid, and `busy`, `drainReq`, `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rrWe | input | 1 | Region register write enable |
| rrIdx | input | 3 | Region register index |
| rrRid | input | RID_W | Region identifier to write |
| fillValid | input | 1 | Fill strobe |
| fillSide | input | 1 | Fill array: 0 instruction, 1 data |
| fillIdx | input | IDX_W | Fill slot |
| fillAddr | input | 64 | Fill address (region in bits 63:61) |
| fillPs | input | 6 | Fill page size, log2 bytes |
| lookSide | input | 1 | Lookup array select |
| lookAddr | input | 64 | Lookup address |
| lookHit | output | 1 | Lookup hit |
| cmdValid | input | 1 | Purge command strobe |
| cmdQp | input | 1 | Qualifying predicate |
| cmdAddr | input | 64 | Purge address operand |
| cmdSize | input | 64 | Purge size operand (log2 in bits 7:2) |
| cmdAddrNat | input | 1 | Not-a-thing flag of address operand |
| cmdSizeNat | input | 1 | Not-a-thing flag of size operand |
| curPl | input | 2 | Current privilege level |
| virtMode | input | 1 | Virtualization mode bit |
| drainReq | output | 1 | Store drain request |
| drainAck | input | 1 | Store drain acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| fault | output | 1 | Fault pulse, with done |
| faultCode | output | 3 | 0 none, 1 privilege, 2 not-a-thing, 3 unimplemented, 4 virtualization |

## Verification
The hardest case to reach is an entry that survives a purge only because of the order of events around the drain handshake. A fill that arrives while the block waits for the acknowledge must not land. An entry that has not yet been swept must still hit during that wait. The bench holds `drainAck` low for several cycles and probes lookups each cycle. It drives a fill in that window and raises the acknowledge only afterwards. Faults with several failing checks at once are stacked on one command so that the priority order is what decides the reported code.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_PRIV   = 3'd1,
    FLT_NAT    = 3'd2,
    FLT_UNIMPL = 3'd3,
    FLT_VIRT   = 3'd4
  } faultCode_e;

  typedef struct packed {
    logic latchCmd;  // capture region id, base and size of an accepted purge
    logic sweep;     // invalidate every overlapping entry this cycle
  } ctrlStrobe_t;

  // Mask that keeps address bits at or above position ps (61-bit space).
  function automatic logic [60:0] sizeMask(input logic [5:0] ps);
    return (~61'd0) << ps;
  endfunction
endpackage

// File: rtl/tcp_ctrl.sv
module tcp_ctrl
  import tcp_pkg::*;
#(
  parameter int VA_IMPL = 51,
  localparam int HI_W = 61 - VA_IMPL
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic            cmdQp,
  input  logic [HI_W-1:0] addrHigh,
  input  logic            cmdAddrNat,
  input  logic            cmdSizeNat,
  input  logic [1:0]      curPl,
  input  logic            virtMode,
  input  logic            drainAck,
  output ctrlStrobe_t     strobe,
  output logic            drainReq,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [2:0]      faultCode
);
  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_SWEEP} state_e;

  state_e     state;
  faultCode_e checkCode;
  logic       accept;

  // Ranked checks: the first failing one wins.
  always_comb begin
    if (curPl != 2'd0)                 checkCode = FLT_PRIV;
    else if (cmdAddrNat || cmdSizeNat) checkCode = FLT_NAT;
    else if (|addrHigh)                checkCode = FLT_UNIMPL;
    else if (virtMode)                 checkCode = FLT_VIRT;
    else                               checkCode = FLT_NONE;
  end

  assign accept          = cmdValid && (state == ST_IDLE);
  assign strobe.latchCmd = accept && cmdQp && (checkCode == FLT_NONE);
  assign strobe.sweep    = (state == ST_SWEEP);
  assign drainReq        = (state == ST_DRAIN);
  assign busy            = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      fault     <= 1'b0;
      faultCode <= FLT_NONE;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (!cmdQp) begin
            done      <= 1'b1;
            faultCode <= FLT_NONE;
          end else if (checkCode != FLT_NONE) begin
            done      <= 1'b1;
            fault     <= 1'b1;
            faultCode <= checkCode;
          end else begin
            faultCode <= FLT_NONE;
            state     <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (drainAck) state <= ST_SWEEP;
        ST_SWEEP: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcp_datapath.sv
module tcp_datapath
  import tcp_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int RID_W   = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rrWe,
  input  logic [2:0]       rrIdx,
  input  logic [RID_W-1:0] rrRid,
  input  logic             fillEnable,
  input  logic             fillValid,
  input  logic             fillSide,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [63:0]      fillAddr,
  input  logic [5:0]       fillPs,
  input  logic             lookSide,
  input  logic [63:0]      lookAddr,
  output logic             lookHit,
  input  ctrlStrobe_t      strobe,
  input  logic [63:0]      cmdAddr,
  input  logic [5:0]       cmdSizeLog2
);
  localparam int SIDES = 2;

  logic [RID_W-1:0] regionRid [8];
  logic [RID_W-1:0] purgeRid;
  logic [60:0]      purgeVa;
  logic [5:0]       purgePs;

  logic             entValid [SIDES][ENTRIES];
  logic [RID_W-1:0] entRid   [SIDES][ENTRIES];
  logic [60:0]      entBase  [SIDES][ENTRIES];
  logic [5:0]       entPs    [SIDES][ENTRIES];
  logic             purgeHit [SIDES][ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) regionRid[i] <= '0;
    end else if (rrWe) begin
      regionRid[rrIdx] <= rrRid;
    end
  end

  // Capture of the accepted purge; the base is aligned to the range size here.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      purgeRid <= '0;
      purgeVa  <= '0;
      purgePs  <= '0;
    end else if (strobe.latchCmd) begin
      purgeRid <= regionRid[cmdAddr[63:61]];
      purgeVa  <= cmdAddr[60:0] & sizeMask(cmdSizeLog2);
      purgePs  <= cmdSizeLog2;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : gSide
    for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
      logic [5:0] wideLog2;
      logic       fillHere;

      // Two size-aligned blocks overlap exactly when they agree above the larger size.
      assign wideLog2 = (entPs[s][e] > purgePs) ? entPs[s][e] : purgePs;
      assign purgeHit[s][e] = entValid[s][e] && (entRid[s][e] == purgeRid) &&
                              (((entBase[s][e] ^ purgeVa) & sizeMask(wideLog2)) == '0);
      assign fillHere = fillEnable && fillValid && (fillSide == 1'(s)) &&
                        (fillIdx == IDX_W'(e));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entValid[s][e] <= 1'b0;
          entRid[s][e]   <= '0;
          entBase[s][e]  <= '0;
          entPs[s][e]    <= '0;
        end else if (strobe.sweep && purgeHit[s][e]) begin
          entValid[s][e] <= 1'b0;
        end else if (fillHere) begin
          entValid[s][e] <= 1'b1;
          entRid[s][e]   <= regionRid[fillAddr[63:61]];
          entBase[s][e]  <= fillAddr[60:0] & sizeMask(fillPs);
          entPs[s][e]    <= fillPs;
        end
      end
    end
  end

  always_comb begin
    lookHit = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (entValid[lookSide][e] &&
          (entRid[lookSide][e] == regionRid[lookAddr[63:61]]) &&
          (((entBase[lookSide][e] ^ lookAddr[60:0]) & sizeMask(entPs[lookSide][e])) == '0))
        lookHit = 1'b1;
    end
  end
endmodule

// File: rtl/tc_range_purge.sv
module tc_range_purge
  import tcp_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int RID_W   = 24,
  parameter int VA_IMPL = 51,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rrWe,
  input  logic [2:0]       rrIdx,
  input  logic [RID_W-1:0] rrRid,
  input  logic             fillValid,
  input  logic             fillSide,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [63:0]      fillAddr,
  input  logic [5:0]       fillPs,
  input  logic             lookSide,
  input  logic [63:0]      lookAddr,
  output logic             lookHit,
  input  logic             cmdValid,
  input  logic             cmdQp,
  input  logic [63:0]      cmdAddr,
  input  logic [63:0]      cmdSize,
  input  logic             cmdAddrNat,
  input  logic             cmdSizeNat,
  input  logic [1:0]       curPl,
  input  logic             virtMode,
  output logic             drainReq,
  input  logic             drainAck,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [2:0]       faultCode
);
  ctrlStrobe_t strobe;
  logic        unusedSizeBits;

  assign unusedSizeBits = ^{cmdSize[63:8], cmdSize[1:0]};

  tcp_ctrl #(.VA_IMPL(VA_IMPL)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdQp(cmdQp),
    .addrHigh(cmdAddr[60:VA_IMPL]), .cmdAddrNat(cmdAddrNat), .cmdSizeNat(cmdSizeNat),
    .curPl(curPl), .virtMode(virtMode), .drainAck(drainAck), .strobe(strobe),
    .drainReq(drainReq), .busy(busy), .done(done), .fault(fault), .faultCode(faultCode)
  );

  tcp_datapath #(.ENTRIES(ENTRIES), .RID_W(RID_W)) dp_i (
    .clk(clk), .rstN(rstN), .rrWe(rrWe), .rrIdx(rrIdx), .rrRid(rrRid),
    .fillEnable(!busy), .fillValid(fillValid), .fillSide(fillSide), .fillIdx(fillIdx),
    .fillAddr(fillAddr), .fillPs(fillPs), .lookSide(lookSide), .lookAddr(lookAddr),
    .lookHit(lookHit), .strobe(strobe), .cmdAddr(cmdAddr), .cmdSizeLog2(cmdSize[7:2])
  );
endmodule

// File: rtl/tcp_checker.sv
module tcp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       cmdQp,
  input logic [1:0] curPl,
  input logic       busy,
  input logic       done,
  input logic       fault,
  input logic [2:0] faultCode,
  input logic       drainReq,
  input logic       drainAck
);
  assert_priv_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdQp && curPl != 2'd0) |=> (fault && faultCode == 3'd1));

  assert_priv_no_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdQp && curPl != 2'd0) |=> !drainReq);

  assert_noop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && !cmdQp) |=> (done && !fault));

  assert_drain_wait_R11: assert property (@(posedge clk) disable iff (!rstN)
    (drainReq && !drainAck) |=> (drainReq && !done));

  assert_fault_report_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && faultCode != 3'd0));
endmodule

bind tc_range_purge tcp_checker chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdQp(cmdQp), .curPl(curPl),
  .busy(busy), .done(done), .fault(fault), .faultCode(faultCode),
  .drainReq(drainReq), .drainAck(drainAck)
);

// File: tb/tc_range_purge_tb_top.sv
`timescale 1ns/1ps
module tc_range_purge_tb_top;
  localparam int ENTRIES = 4;
  localparam int RID_W   = 24;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rrWe = 1'b0;
  logic [2:0] rrIdx = '0;
  logic [RID_W-1:0] rrRid = '0;
  logic fillValid = 1'b0, fillSide = 1'b0;
  logic [IDX_W-1:0] fillIdx = '0;
  logic [63:0] fillAddr = '0;
  logic [5:0] fillPs = '0;
  logic lookSide = 1'b0;
  logic [63:0] lookAddr = '0;
  logic lookHit;
  logic cmdValid = 1'b0, cmdQp = 1'b0;
  logic [63:0] cmdAddr = '0, cmdSize = '0;
  logic cmdAddrNat = 1'b0, cmdSizeNat = 1'b0;
  logic [1:0] curPl = '0;
  logic virtMode = 1'b0;
  logic drainReq, drainAck = 1'b0;
  logic busy, done, fault;
  logic [2:0] faultCode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tc_range_purge #(.ENTRIES(ENTRIES), .RID_W(RID_W)) dut_i (.*);

  function automatic logic [63:0] mkAddr(input logic [2:0] region, input logic [60:0] va);
    return {region, va};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setRegion(input logic [2:0] idx, input logic [RID_W-1:0] rid);
    @(negedge clk); rrWe = 1'b1; rrIdx = idx; rrRid = rid;
    @(negedge clk); rrWe = 1'b0;
  endtask

  task automatic fill(input bit side, input int idx, input logic [63:0] addr, input logic [5:0] ps);
    @(negedge clk);
    fillValid = 1'b1; fillSide = side; fillIdx = IDX_W'(idx); fillAddr = addr; fillPs = ps;
    @(negedge clk); fillValid = 1'b0;
  endtask

  task automatic expectLook(input bit side, input logic [63:0] addr, input bit exp, input string req);
    lookSide = side; lookAddr = addr;
    #0.5;
    check(lookHit == exp, req, 64'(lookHit), 64'(exp));
  endtask

  task automatic driveCmd(input bit qp, input logic [63:0] addr, input logic [5:0] ps,
                          input bit aNat, input bit sNat, input logic [1:0] pl, input bit vm);
    @(negedge clk);
    cmdValid = 1'b1; cmdQp = qp; cmdAddr = addr; cmdSize = {56'd0, ps, 2'b11};
    cmdAddrNat = aNat; cmdSizeNat = sNat; curPl = pl; virtMode = vm;
    @(negedge clk);
    cmdValid = 1'b0; cmdAddrNat = 1'b0; cmdSizeNat = 1'b0; curPl = 2'd0; virtMode = 1'b0;
  endtask

  // Runs a command expected to fault (or be predicated off) and checks the report.
  task automatic faultCmd(input bit qp, input logic [63:0] addr, input logic [5:0] ps,
                          input bit aNat, input bit sNat, input logic [1:0] pl, input bit vm,
                          input logic [2:0] expCode, input string req);
    driveCmd(qp, addr, ps, aNat, sNat, pl, vm);
    check(done == 1'b1, req, 64'(done), 64'd1);
    check(fault == (expCode != 3'd0), req, 64'(fault), 64'(expCode != 3'd0));
    check(faultCode == expCode, req, 64'(faultCode), 64'(expCode));
    check(drainReq == 1'b0, req, 64'(drainReq), 64'd0);
  endtask

  // Runs a passing purge with a drain wait of holdCycles, probing one address while waiting.
  task automatic goodPurge(input logic [63:0] addr, input logic [5:0] ps, input int holdCycles,
                           input bit probeSide, input logic [63:0] probeAddr);
    driveCmd(1'b1, addr, ps, 1'b0, 1'b0, 2'd0, 1'b0);
    for (int i = 0; i < holdCycles; i++) begin
      check(drainReq == 1'b1 && done == 1'b0, "R11 drain held", {drainReq, done}, 64'h2);
      expectLook(probeSide, probeAddr, 1'b1, "R11 entry kept before drain ack");
      @(negedge clk);
    end
    drainAck = 1'b1;
    @(negedge clk); drainAck = 1'b0;
    check(done == 1'b0 && drainReq == 1'b0, "R11 sweep cycle", {drainReq, done}, 64'h0);
    @(negedge clk);
    check(done == 1'b1 && fault == 1'b0 && busy == 1'b0, "R11 done after sweep",
          {done, fault, busy}, 64'h4);
  endtask

  task automatic testReset();
    check(busy == 1'b0 && drainReq == 1'b0 && done == 1'b0 && fault == 1'b0,
          "R13 outputs idle", {busy, drainReq, done, fault}, 64'h0);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 4; a++)
        expectLook(s[0], mkAddr(3'd0, 61'(a) << 12), 1'b0, "R13 no entry after reset");
  endtask

  task automatic testFillLookup();
    fill(1'b1, 0, mkAddr(3'd1, 61'h10000), 6'd12);
    expectLook(1'b1, mkAddr(3'd1, 61'h10ABC), 1'b1, "R1 hit inside page");
    expectLook(1'b1, mkAddr(3'd1, 61'h11000), 1'b0, "R1 miss past page");
    expectLook(1'b0, mkAddr(3'd1, 61'h10ABC), 1'b0, "R1 other side misses");
    expectLook(1'b1, mkAddr(3'd2, 61'h10ABC), 1'b0, "R1 other region misses");
    expectLook(1'b1, mkAddr(3'd3, 61'h10ABC), 1'b1, "R1 region with same id hits");
  endtask

  task automatic testRangePurge();
    fill(1'b1, 1, mkAddr(3'd1, 61'h20000), 6'd12);
    fill(1'b1, 2, mkAddr(3'd2, 61'h10000), 6'd12);
    fill(1'b1, 3, mkAddr(3'd1, 61'h400000), 6'd20);
    fill(1'b0, 0, mkAddr(3'd1, 61'h10000), 6'd16);
    // Unaligned 4 KiB purge at 0x10800 removes the data page and the covering 64 KiB page.
    goodPurge(mkAddr(3'd1, 61'h10800), 6'd12, 3, 1'b1, mkAddr(3'd1, 61'h10000));
    expectLook(1'b1, mkAddr(3'd1, 61'h10000), 1'b0, "R4 aligned base removes data page");
    expectLook(1'b0, mkAddr(3'd1, 61'h18000), 1'b0, "R2 larger instruction page removed");
    expectLook(1'b1, mkAddr(3'd1, 61'h20000), 1'b1, "R3 non-overlapping page kept");
    expectLook(1'b1, mkAddr(3'd2, 61'h10000), 1'b1, "R3 other region kept");
    expectLook(1'b1, mkAddr(3'd1, 61'h400000), 1'b1, "R3 far large page kept");
    // 16 KiB range inside a 1 MiB page.
    goodPurge(mkAddr(3'd1, 61'h400123), 6'd14, 1, 1'b1, mkAddr(3'd1, 61'h480000));
    expectLook(1'b1, mkAddr(3'd1, 61'h480000), 1'b0, "R2 page containing range removed");
    // 256 KiB range through region 3 (same id) covering a 4 KiB page.
    goodPurge(mkAddr(3'd3, 61'h0), 6'd18, 1, 1'b1, mkAddr(3'd1, 61'h20000));
    expectLook(1'b1, mkAddr(3'd1, 61'h20000), 1'b0, "R2 range containing page removed");
    expectLook(1'b1, mkAddr(3'd2, 61'h10000), 1'b1, "R3 other region survives wide purge");
  endtask

  task automatic testFaults();
    logic [63:0] tgt;
    logic [63:0] hiAddr;
    tgt    = mkAddr(3'd1, 61'h10000);
    hiAddr = mkAddr(3'd1, 61'h10000 | (61'd1 << 55));
    fill(1'b1, 0, tgt, 6'd12);
    faultCmd(1'b1, tgt, 6'd12, 1'b0, 1'b0, 2'd3, 1'b0, 3'd1, "R5 privilege fault");
    expectLook(1'b1, tgt, 1'b1, "R5 entry unchanged after privilege fault");
    faultCmd(1'b1, tgt, 6'd12, 1'b1, 1'b0, 2'd0, 1'b0, 3'd2, "R6 address nat fault");
    faultCmd(1'b1, tgt, 6'd12, 1'b0, 1'b1, 2'd0, 1'b0, 3'd2, "R6 size nat fault");
    faultCmd(1'b1, hiAddr, 6'd12, 1'b0, 1'b0, 2'd0, 1'b0, 3'd3, "R7 unimplemented address");
    faultCmd(1'b1, tgt, 6'd12, 1'b0, 1'b0, 2'd0, 1'b1, 3'd4, "R8 virtualization fault");
    faultCmd(1'b1, hiAddr, 6'd12, 1'b1, 1'b1, 2'd1, 1'b1, 3'd1, "R9 privilege outranks all");
    faultCmd(1'b1, hiAddr, 6'd12, 1'b1, 1'b0, 2'd0, 1'b1, 3'd2, "R9 nat outranks address");
    faultCmd(1'b1, hiAddr, 6'd12, 1'b0, 1'b0, 2'd0, 1'b1, 3'd3, "R9 address outranks virt");
    expectLook(1'b1, tgt, 1'b1, "R9 entry unchanged after faults");
  endtask

  task automatic testQpOff();
    logic [63:0] tgt;
    tgt = mkAddr(3'd1, 61'h10000);
    faultCmd(1'b0, tgt, 6'd12, 1'b1, 1'b0, 2'd3, 1'b1, 3'd0, "R10 predicate off");
    expectLook(1'b1, tgt, 1'b1, "R10 entry unchanged");
  endtask

  task automatic testBusyBlocks();
    logic [63:0] tgt;
    tgt = mkAddr(3'd1, 61'h10000);
    driveCmd(1'b1, mkAddr(3'd1, 61'h800000), 6'd12, 1'b0, 1'b0, 2'd0, 1'b0);
    check(busy == 1'b1, "R12 busy during drain", 64'(busy), 64'd1);
    // Fill and a second command while busy; neither may take effect.
    fillValid = 1'b1; fillSide = 1'b1; fillIdx = IDX_W'(3);
    fillAddr = mkAddr(3'd1, 61'h900000); fillPs = 6'd12;
    cmdValid = 1'b1; cmdQp = 1'b1; cmdAddr = tgt; cmdSize = {56'd0, 6'd12, 2'b00};
    @(negedge clk);
    fillValid = 1'b0; cmdValid = 1'b0;
    expectLook(1'b1, mkAddr(3'd1, 61'h900000), 1'b0, "R12 fill ignored while busy");
    drainAck = 1'b1;
    @(negedge clk); drainAck = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R12 purge completes", 64'(done), 64'd1);
    @(negedge clk);
    check(busy == 1'b0 && drainReq == 1'b0, "R12 queued command ignored",
          {busy, drainReq}, 64'h0);
    expectLook(1'b1, tgt, 1'b1, "R12 command ignored while busy left entry");
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    setRegion(3'd1, 24'h11);
    setRegion(3'd2, 24'h22);
    setRegion(3'd3, 24'h11);
    testFillLookup();
    testRangePurge();
    testFaults();
    testQpOff();
    testBusyBlocks();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule